// File: doc/BRIEF.md
# Correlating Accumulator Error Extractor

This block pulls a small injected error term out of a stream of signed conversion results. A pseudo-random chip sequence is applied to every accepted sample: the sample is added to a wide accumulator when the chip is 0 and subtracted when the chip is 1. Any component that is not correlated with the chip pattern averages out over the window. The block has no multiplier. It applies the ±1 weighting with a conditional add or subtract, and a plain accumulator serves as the low-pass filter.

A start pulse begins a run. The block integrates windows of exactly M valid samples, one after another. After each window it registers the sum as an estimate, pulses a done flag, zeroes the accumulator and reseeds the chip generator. Every window therefore sees the same chip pattern. M is a power of two chosen at start. The long choice, 2^28 by default, is for background operation. The short choice, 2^16 by default, is for fast power-up calibration. Both exponents are parameters, so a bench can shrink them. A clear pulse stops the run.

Top module: `corr_err_extract`

## Requirements
- R1: After a synchronous active-high reset, `est_o` is 0, `done_o` is 0 and the block is idle.
- R2: The chip sequence comes from a 31-bit Fibonacci LFSR. The seed is 1. The next state is `{s[29:0], s[30]^s[27]}` and the chip is `s[0]`. The first sample of a window uses the seed's chip. Chip 1 subtracts the sample from the accumulator and chip 0 adds it.
- R3: Each sample is two's complement of `SAMP_W` bits. It is sign-extended to `ACC_W` bits before the add or subtract.
- R4: The window length M is 2^LONG_LOG2 when `len_sel_i`=0 and 2^SHORT_LOG2 when `len_sel_i`=1. The value is captured when a start is accepted, and later changes to `len_sel_i` have no effect until the next start.
- R5: The clock edge that accepts the M-th valid sample of a window loads `est_o` with the full signed sum of that window. `done_o` is 1 for exactly the one cycle that follows that edge.
- R6: `est_o` holds its value until the next window completes, including across a clear and a restart.
- R7: Valid samples are ignored while the block is idle, and also in any cycle where start or clear is high.
- R8: Cycles with `smp_valid_i`=0 do not advance the window. A window closes after exactly M valid samples, whatever gaps occur between them.
- R9: When a window closes during a run, the accumulator returns to 0 and the LFSR returns to its seed. The same M inputs in the next window give the same estimate.
- R10: `clear_i` returns the block to idle and discards the partial sum. When `clear_i` and `start_i` are high in the same cycle, clear wins and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin or restart a run; captures the window length |
| clear_i | input | 1 | Stop the run and drop the partial sum |
| len_sel_i | input | 1 | Window length select: 0 long, 1 short |
| smp_valid_i | input | 1 | Sample strobe |
| smp_i | input | SAMP_W | Signed sample |
| est_o | output | ACC_W | Registered estimate |
| done_o | output | 1 | One-cycle pulse when the estimate updates |

## Verification
A start needs one clock edge before samples count. The estimate and the done pulse appear right after the edge that accepts the M-th valid sample, and done drops one cycle later. The bench drives inputs on the falling edge and reads outputs on the next falling edge, half a cycle after the edge that registers them. This lets it require done high on exactly that sample and low on every other one. Periods where nothing should change (idle valids, clear, clear together with start, a changed length select) are each followed by reads of the estimate and done before any new window can close.

// File: rtl/cae_pkg.sv
package cae_pkg;
  localparam int LFSR_W = 31;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 31'h1;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[30] ^ s[27]};
  endfunction
endpackage

// File: rtl/cae_chip_gen.sv
module cae_chip_gen
  import cae_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic reseed_i,
  input  logic adv_i,
  output logic chip_o
);
  logic [LFSR_W-1:0] state;

  always_ff @(posedge clk) begin
    if (rst || reseed_i) state <= LFSR_SEED;
    else if (adv_i)      state <= lfsr_step(state);
  end

  assign chip_o = state[0];

  // R2: a maximal-length register never reaches the all-zero lockup state
  a_r2_lfsr_nonzero: assert property (@(posedge clk) disable iff (rst)
    state != '0);
  // R9: a window boundary leaves the generator at its seed
  a_r9_reseed: assert property (@(posedge clk) disable iff (rst)
    reseed_i |=> state == LFSR_SEED);
endmodule

// File: rtl/cae_window_ctl.sv
module cae_window_ctl #(
  parameter int LONG_LOG2  = 28,
  parameter int SHORT_LOG2 = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic clear_i,
  input  logic len_sel_i,
  input  logic valid_i,
  output logic take_o,
  output logic last_o,
  output logic restart_o
);
  localparam int CNT_W = LONG_LOG2;
  localparam logic [CNT_W-1:0] LONG_MASK  = '1;
  localparam logic [CNT_W-1:0] SHORT_MASK =
    {{(CNT_W-SHORT_LOG2){1'b0}}, {SHORT_LOG2{1'b1}}};

  logic             running;
  logic             short_mode;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim       = short_mode ? SHORT_MASK : LONG_MASK;
  assign restart_o = start_i || clear_i;
  assign take_o    = running && valid_i && !restart_o;
  assign last_o    = take_o && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      running    <= 1'b0;
      short_mode <= 1'b0;
      cnt        <= '0;
    end else if (clear_i) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (start_i) begin
      running    <= 1'b1;
      short_mode <= len_sel_i;
      cnt        <= '0;
    end else if (take_o) begin
      cnt <= last_o ? '0 : cnt + 1'b1;
    end
  end

  // R8: the sample count never passes the end of the selected window
  a_r8_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= lim);
  // R10: clear always leaves the block idle
  a_r10_clear_idles: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> !running);
  // R4: the captured length cannot change without a start
  a_r4_mode_held: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> $stable(short_mode));
endmodule

// File: rtl/cae_integrator.sv
module cae_integrator #(
  parameter int SAMP_W = 16,
  parameter int ACC_W  = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_i,
  input  logic              last_i,
  input  logic              restart_i,
  input  logic              chip_i,
  input  logic [SAMP_W-1:0] smp_i,
  output logic [ACC_W-1:0]  est_o,
  output logic              done_o
);
  localparam int EXT_W = ACC_W - SAMP_W;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] ext;
  logic [ACC_W-1:0] sum;

  assign ext = {{EXT_W{smp_i[SAMP_W-1]}}, smp_i};
  assign sum = chip_i ? (acc - ext) : (acc + ext);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      est_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= last_i;
      if (restart_i) begin
        acc <= '0;
      end else if (last_i) begin
        est_o <= sum;
        acc   <= '0;
      end else if (take_i) begin
        acc <= sum;
      end
    end
  end

  // R5: done is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R6: the estimate moves only together with done
  a_r6_est_hold: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(est_o));
  // R7: without an accepted sample or restart the accumulator is frozen
  a_r7_idle_acc_hold: assert property (@(posedge clk) disable iff (rst)
    (!take_i && !restart_i) |=> $stable(acc));
endmodule

// File: rtl/corr_err_extract.sv
module corr_err_extract #(
  parameter int SAMP_W     = 16,
  parameter int ACC_W      = 48,
  parameter int LONG_LOG2  = 28,
  parameter int SHORT_LOG2 = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              clear_i,
  input  logic              len_sel_i,
  input  logic              smp_valid_i,
  input  logic [SAMP_W-1:0] smp_i,
  output logic [ACC_W-1:0]  est_o,
  output logic              done_o
);
  logic take, last, restart, chip;

  cae_window_ctl #(
    .LONG_LOG2 (LONG_LOG2),
    .SHORT_LOG2(SHORT_LOG2)
  ) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .clear_i  (clear_i),
    .len_sel_i(len_sel_i),
    .valid_i  (smp_valid_i),
    .take_o   (take),
    .last_o   (last),
    .restart_o(restart)
  );

  cae_chip_gen u_chip (
    .clk     (clk),
    .rst     (rst),
    .reseed_i(restart || last),
    .adv_i   (take),
    .chip_o  (chip)
  );

  cae_integrator #(
    .SAMP_W(SAMP_W),
    .ACC_W (ACC_W)
  ) u_int (
    .clk      (clk),
    .rst      (rst),
    .take_i   (take),
    .last_i   (last),
    .restart_i(restart),
    .chip_i   (chip),
    .smp_i    (smp_i),
    .est_o    (est_o),
    .done_o   (done_o)
  );
endmodule

// File: tb/corr_err_extract_tb.sv
module corr_err_extract_tb;
  localparam int SW = 16;
  localparam int AW = 48;
  localparam int LL = 6;
  localparam int SL = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst, start, clr, sel, vld;
  logic [SW-1:0] smp;
  logic [AW-1:0] est;
  logic          done;
  int checks = 0;
  int fails  = 0;

  corr_err_extract #(.SAMP_W(SW), .ACC_W(AW), .LONG_LOG2(LL), .SHORT_LOG2(SL)) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .clear_i(clr), .len_sel_i(sel),
    .smp_valid_i(vld), .smp_i(smp), .est_o(est), .done_o(done));

  // vector: {short_sel, gaps, base[15:0], step[15:0]}
  localparam int NV = 6;
  localparam logic [33:0] VEC [NV] = '{
    {1'b1, 1'b0, 16'h0005, 16'h0003},
    {1'b1, 1'b1, 16'h8000, 16'h0001},
    {1'b0, 1'b0, 16'h7FFF, 16'hFFFF},
    {1'b0, 1'b1, 16'hFF00, 16'h0101},
    {1'b1, 1'b0, 16'hFFFF, 16'h0000},
    {1'b0, 1'b0, 16'h1234, 16'hF00D}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [30:0] lstep(input logic [30:0] s);
    return {s[29:0], s[30] ^ s[27]};
  endfunction

  function automatic logic [AW-1:0] model(input bit s, input logic [SW-1:0] base, input logic [SW-1:0] step);
    logic [30:0] st;
    logic [AW-1:0] acc;
    logic [SW-1:0] x;
    logic [AW-1:0] ext;
    int m;
    st = 31'h1;
    acc = '0;
    m = s ? (1 << SL) : (1 << LL);
    for (int i = 0; i < m; i++) begin
      x = base + step * SW'(i);
      ext = {{(AW-SW){x[SW-1]}}, x};
      acc = st[0] ? acc - ext : acc + ext;
      st = lstep(st);
    end
    return acc;
  endfunction

  task automatic pulse_start(input bit s, input bit vld_too);
    @(negedge clk);
    start = 1'b1; sel = s;
    if (vld_too) begin vld = 1'b1; smp = 16'h7FFF; end
    @(negedge clk);
    start = 1'b0; vld = 1'b0;
  endtask

  // Feeds one full window (running assumed); checks done timing and estimate.
  task automatic feed_window(input bit s, input bit gaps, input logic [SW-1:0] base,
                             input logic [SW-1:0] step, input string req);
    int m;
    bit early;
    logic [AW-1:0] exp;
    m = s ? (1 << SL) : (1 << LL);
    early = 1'b0;
    exp = model(s, base, step);
    for (int i = 0; i < m; i++) begin
      if (gaps && (i % 3 == 1)) begin
        vld = 1'b0; smp = 16'h4444;
        @(negedge clk);
        if (done) early = 1'b1;
      end
      vld = 1'b1; smp = base + step * SW'(i);
      @(negedge clk);
      if (done && i != m-1) early = 1'b1;
    end
    vld = 1'b0;
    chk(done === 1'b1, {req, " R5 done after M-th sample"}, 64'(done), 64'd1);
    chk(est === exp, {req, " R2 R3 estimate"}, 64'(est), 64'(exp));
    chk(!early, {req, " R8 no early done"}, 64'(early), 64'd0);
    @(negedge clk);
    chk(done === 1'b0, {req, " R5 done one cycle"}, 64'(done), 64'd0);
  endtask

  bit finished = 1'b0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] held;
    bit seen;
    rst = 1'b1; start = 1'b0; clr = 1'b0; sel = 1'b0; vld = 1'b0; smp = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(est === '0, "R1 reset estimate", 64'(est), 64'd0);
    chk(done === 1'b0, "R1 reset done", 64'(done), 64'd0);

    // R7: valids while idle, and in the start cycle, must be ignored
    vld = 1'b1; smp = 16'h7FFF;
    repeat (5) @(negedge clk);
    vld = 1'b0;
    chk(done === 1'b0 && est === '0, "R7 idle valids", 64'(est), 64'd0);
    pulse_start(1'b1, 1'b1);
    feed_window(1'b1, 1'b0, 16'h0010, 16'h0007, "R7 after idle");

    // Table-driven windows (R2, R3, R4, R8)
    for (int v = 0; v < NV; v++) begin
      pulse_start(VEC[v][33], 1'b0);
      feed_window(VEC[v][33], VEC[v][32], VEC[v][31:16], VEC[v][15:0], $sformatf("vec%0d R4", v));
    end

    // R9: back-to-back window without restart gives same estimate
    pulse_start(1'b1, 1'b0);
    feed_window(1'b1, 1'b0, 16'hFFF0, 16'h0021, "R9 first");
    feed_window(1'b1, 1'b0, 16'hFFF0, 16'h0021, "R9 second");

    // R4: length select changed mid-run has no effect
    pulse_start(1'b1, 1'b0);
    sel = 1'b0;
    feed_window(1'b1, 1'b1, 16'h0100, 16'hFFFE, "R4 capture");

    // R6: partial window leaves estimate alone
    held = est;
    vld = 1'b1; smp = 16'h5555;
    repeat (5) @(negedge clk);
    vld = 1'b0;
    chk(est === held && done === 1'b0, "R6 hold during partial", 64'(est), 64'(held));

    // R10: clear mid-window drops partial sum, estimate held
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk(est === held, "R10 clear keeps estimate", 64'(est), 64'(held));
    vld = 1'b1; smp = 16'h1111;
    seen = 1'b0;
    repeat (20) begin @(negedge clk); if (done) seen = 1'b1; end
    vld = 1'b0;
    chk(!seen && est === held, "R10 idle after clear", 64'(seen), 64'd0);

    // R10: clear beats start
    @(negedge clk);
    start = 1'b1; clr = 1'b1; sel = 1'b1;
    @(negedge clk);
    start = 1'b0; clr = 1'b0;
    vld = 1'b1; smp = 16'h2222;
    seen = 1'b0;
    repeat (20) begin @(negedge clk); if (done) seen = 1'b1; end
    vld = 1'b0;
    chk(!seen, "R10 clear wins over start", 64'(seen), 64'd0);
    chk(est === held, "R6 estimate held across clear", 64'(est), 64'(held));

    // Restart after clear: partial sums gone (R10, R9)
    pulse_start(1'b0, 1'b0);
    feed_window(1'b0, 1'b0, 16'h0003, 16'h0002, "R10 restart");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule